// File: doc/BRIEF.md
# Flash Block Lock-Bit Protection Controller

This controller decides whether program and erase requests may proceed on a flash array that is divided into `NUM_BLK` blocks. Each block keeps one lock bit. A 0 in that bit protects the block, and a 1 leaves it open. A single command port takes four operations: program, block erase, lock-bit program and lock-status read. Each accepted operation takes the busy flag low for a fixed, parameterised number of cycles.

Software can write a global lock-disable bit. While that bit is set, every block is treated as open, but the stored lock bits do not change. Hardware clears the bit when the busy flag returns to ready. It also clears the bit when any of four abort inputs is high: command-sequence error, CPU-mode off, flash stop or command reset. Erasing a block is the only way to set its lock bit back to 1. Software must therefore set lock-disable again before each operation on a protected block.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset, `ready_o`=1, `lock_dis_o`=0, `err_o`=0 and `rd_valid_o`=0, and every lock bit reads 1 (open).
- R2: The opcode on `cmd_op_i` is 0 for program, 1 for erase, 2 for lock-bit program and 3 for status read. A lock-bit program is always accepted, whatever the lock state, and it leaves the target lock bit at 0 when it completes.
- R3: A program or erase is rejected when the target lock bit is 0 and `lock_dis_o` was 0 before the command cycle. On rejection, `ready_o` stays 1 and `err_o` becomes 1. `err_o` then stays 1 until reset.
- R4: Writing lock-disable (`dis_wr_i` with `dis_val_i`) shows on `lock_dis_o` one cycle later. While it is 1, program and erase are accepted on locked blocks, and the stored lock bits read back unchanged.
- R5: An erase sets the target lock bit to 1 on completion. A program never alters a lock bit. Lock bits change only on the edge where `ready_o` rises.
- R6: `lock_dis_o` is 0 from the edge where an operation completes. A software write to lock-disable that falls on that same edge loses to the clear.
- R7: Any of `seq_err_i`, `cpu_off_i`, `flash_stop_i` or `cmd_rst_i` being high clears `lock_dis_o` on the next edge. This clear wins over a software write in the same cycle.
- R8: `ready_o` stays low for exactly 4, 12 or 6 cycles (default parameters) for program, erase and lock-bit program. Commands presented while busy are ignored, including reads (no `rd_valid_o`).
- R9: `cmd_rst_i` aborts a running operation, so `ready_o` is 1 on the next edge. The target lock bit is not changed, and a command presented in the same cycle is ignored.
- R10: A status read issued while ready gives `rd_valid_o`=1 for one cycle on the next edge. In that cycle `rd_lock_o` equals the addressed stored lock bit, and the read does not take the block busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Opcode (0 program, 1 erase, 2 lock program, 3 read) |
| cmd_blk_i | input | BLK_W | Target block index |
| dis_wr_i | input | 1 | Write strobe for lock-disable |
| dis_val_i | input | 1 | Value to write to lock-disable |
| seq_err_i | input | 1 | Command-sequence error |
| cpu_off_i | input | 1 | CPU-mode disable |
| flash_stop_i | input | 1 | Flash stop |
| cmd_rst_i | input | 1 | Command reset / abort |
| ready_o | output | 1 | 1 ready, 0 busy |
| lock_dis_o | output | 1 | Current lock-disable bit |
| err_o | output | 1 | Sticky rejection flag |
| rd_valid_o | output | 1 | Status read result valid |
| rd_lock_o | output | 1 | Stored lock bit of the read block |

## Verification
Two events can land on the same edge: a software write that sets lock-disable, and a hardware clear of that bit caused by completion or abort. The bench provokes this in two ways. It times a lock-disable write to fall exactly on the completion edge of a program. It also raises the write together with a sequence-error pulse. In both cases it judges the result by `lock_dis_o` reading 0 afterwards. A second overlap, command reset arriving in the same cycle as a new command, is judged by reading back the lock bit the ignored command targeted.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_LOCK  = 2'd2,
    OP_READ  = 2'd3
  } fl_op_e;
endpackage

// File: rtl/flash_lock_gate.sv
module flash_lock_gate import flash_lock_pkg::*; #(
  parameter int NUM_BLK = 8,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               cmd_valid_i,
  input  fl_op_e             cmd_op_i,
  input  logic [BLK_W-1:0]   cmd_blk_i,
  input  logic               ready_i,
  input  logic               halt_i,
  input  logic               lock_dis_i,
  input  logic [NUM_BLK-1:0] lock_vec_i,
  output logic               start_o,
  output logic               reject_o,
  output logic               rd_req_o,
  output logic               rd_bit_o
);
  localparam logic [BLK_W:0] NUM_L = (BLK_W+1)'(NUM_BLK);

  logic live, is_pe, blocked, sel;

  assign live    = cmd_valid_i && ready_i && !halt_i && ({1'b0, cmd_blk_i} < NUM_L);
  assign sel     = lock_vec_i[cmd_blk_i];
  assign is_pe   = (cmd_op_i == OP_PROG) || (cmd_op_i == OP_ERASE);
  assign blocked = is_pe && !sel && !lock_dis_i;

  assign start_o  = live && ((cmd_op_i == OP_LOCK) || (is_pe && !blocked));
  assign reject_o = live && blocked;
  assign rd_req_o = live && (cmd_op_i == OP_READ);
  assign rd_bit_o = sel;
endmodule

// File: rtl/flash_lock_timer.sv
module flash_lock_timer import flash_lock_pkg::*; #(
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 12,
  parameter int LOCK_CYC  = 6
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  fl_op_e op_i,
  input  logic   abort_i,
  output logic   busy_o,
  output logic   done_o
);
  localparam int MAX_PE  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_CYC = (MAX_PE > LOCK_CYC) ? MAX_PE : LOCK_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q, len;

  always_comb begin
    unique case (op_i)
      OP_PROG:  len = CNT_W'(PROG_CYC - 1);
      OP_ERASE: len = CNT_W'(ERASE_CYC - 1);
      default:  len = CNT_W'(LOCK_CYC - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= len;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_o && (cnt_q == '0) && !abort_i;
endmodule

// File: rtl/flash_lock_bits.sv
module flash_lock_bits #(
  parameter int NUM_BLK = 8,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_val_i,
  input  logic [BLK_W-1:0]   blk_i,
  output logic [NUM_BLK-1:0] lock_o
);
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             bit_q <= 1'b1;
      else if (wr_en_i && blk_i == BLK_W'(g))  bit_q <= wr_val_i;
    end
    assign lock_o[g] = bit_q;
  end
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl import flash_lock_pkg::*; #(
  parameter int NUM_BLK   = 8,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 12,
  parameter int LOCK_CYC  = 6,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [BLK_W-1:0] cmd_blk_i,
  input  logic             dis_wr_i,
  input  logic             dis_val_i,
  input  logic             seq_err_i,
  input  logic             cpu_off_i,
  input  logic             flash_stop_i,
  input  logic             cmd_rst_i,
  output logic             ready_o,
  output logic             lock_dis_o,
  output logic             err_o,
  output logic             rd_valid_o,
  output logic             rd_lock_o
);
  logic [NUM_BLK-1:0] lock_q;
  logic [BLK_W-1:0]   tgt_blk_q;
  fl_op_e             tgt_op_q, op;
  logic start, reject, rd_req, rd_bit, busy, done, dis_clr;

  assign op      = fl_op_e'(cmd_op_i);
  assign ready_o = !busy;
  // completion and every abort source force lock-disable low
  assign dis_clr = done || seq_err_i || cpu_off_i || flash_stop_i || cmd_rst_i;

  flash_lock_gate #(.NUM_BLK(NUM_BLK)) u_gate (
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (op),
    .cmd_blk_i   (cmd_blk_i),
    .ready_i     (ready_o),
    .halt_i      (cmd_rst_i),
    .lock_dis_i  (lock_dis_o),
    .lock_vec_i  (lock_q),
    .start_o     (start),
    .reject_o    (reject),
    .rd_req_o    (rd_req),
    .rd_bit_o    (rd_bit)
  );

  flash_lock_timer #(
    .PROG_CYC (PROG_CYC),
    .ERASE_CYC(ERASE_CYC),
    .LOCK_CYC (LOCK_CYC)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .op_i    (op),
    .abort_i (cmd_rst_i),
    .busy_o  (busy),
    .done_o  (done)
  );

  flash_lock_bits #(.NUM_BLK(NUM_BLK)) u_bits (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (done && (tgt_op_q != OP_PROG)),
    .wr_val_i (tgt_op_q == OP_ERASE),
    .blk_i    (tgt_blk_q),
    .lock_o   (lock_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_blk_q  <= '0;
      tgt_op_q   <= OP_PROG;
      lock_dis_o <= 1'b0;
      err_o      <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_lock_o  <= 1'b0;
    end else begin
      if (start) begin
        tgt_blk_q <= cmd_blk_i;
        tgt_op_q  <= op;
      end
      if (dis_clr)       lock_dis_o <= 1'b0;
      else if (dis_wr_i) lock_dis_o <= dis_val_i;
      if (reject) err_o <= 1'b1;
      rd_valid_o <= rd_req;
      if (rd_req) rd_lock_o <= rd_bit;
    end
  end
endmodule

// File: rtl/flash_lock_chk.sv
module flash_lock_chk #(
  parameter int NUM_BLK = 8,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cmd_valid_i,
  input logic [1:0]         cmd_op_i,
  input logic [BLK_W-1:0]   cmd_blk_i,
  input logic               seq_err_i,
  input logic               cpu_off_i,
  input logic               flash_stop_i,
  input logic               cmd_rst_i,
  input logic               ready_o,
  input logic               lock_dis_o,
  input logic               err_o,
  input logic               rd_valid_o,
  input logic               rd_lock_o,
  input logic [NUM_BLK-1:0] lock_q
);
  assert_reject_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && ready_o && !cmd_rst_i && (cmd_op_i == 2'd0 || cmd_op_i == 2'd1)
     && !lock_dis_o && !lock_q[cmd_blk_i]) |=> (ready_o && err_o));

  assert_err_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_lock_on_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lock_q) |-> $rose(ready_o));

  assert_done_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> !lock_dis_o);

  assert_abort_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_err_i || cpu_off_i || flash_stop_i || cmd_rst_i) |=> !lock_dis_o);

  assert_busy_no_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> !rd_valid_o);

  assert_cmd_rst_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rst_i |=> ready_o);

  assert_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd3 && ready_o && !cmd_rst_i)
    |=> (rd_valid_o && rd_lock_o == $past(lock_q[cmd_blk_i])));
endmodule

bind flash_lock_ctrl flash_lock_chk #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_op_i     (cmd_op_i),
  .cmd_blk_i    (cmd_blk_i),
  .seq_err_i    (seq_err_i),
  .cpu_off_i    (cpu_off_i),
  .flash_stop_i (flash_stop_i),
  .cmd_rst_i    (cmd_rst_i),
  .ready_o      (ready_o),
  .lock_dis_o   (lock_dis_o),
  .err_o        (err_o),
  .rd_valid_o   (rd_valid_o),
  .rd_lock_o    (rd_lock_o),
  .lock_q       (lock_q)
);

// File: tb/flash_lock_ctrl_test.sv
`timescale 1ns/1ps
module flash_lock_ctrl_test;
  localparam int NB = 8, PC = 4, EC = 12, LC = 6, BW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni, cmd_valid, dis_wr, dis_val, seq_err, cpu_off, flash_stop, cmd_rst;
  logic [1:0] cmd_op;
  logic [BW-1:0] cmd_blk;
  logic ready, lock_dis, err, rd_valid, rd_lock;

  flash_lock_ctrl #(.NUM_BLK(NB), .PROG_CYC(PC), .ERASE_CYC(EC), .LOCK_CYC(LC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_blk_i(cmd_blk), .dis_wr_i(dis_wr), .dis_val_i(dis_val), .seq_err_i(seq_err),
    .cpu_off_i(cpu_off), .flash_stop_i(flash_stop), .cmd_rst_i(cmd_rst),
    .ready_o(ready), .lock_dis_o(lock_dis), .err_o(err), .rd_valid_o(rd_valid),
    .rd_lock_o(rd_lock)
  );

  int n_chk = 0, n_err = 0;
  bit exp_lock[NB];
  bit exp_dis, exp_err;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len_of(int op);
    return (op == 0) ? PC : (op == 1) ? EC : LC;
  endfunction

  function automatic bit accepts(int op, int b);
    return (op == 2) || exp_dis || exp_lock[b];
  endfunction

  task automatic write_dis(bit v);
    dis_wr = 1'b1; dis_val = v;
    @(negedge clk);
    dis_wr = 1'b0;
    exp_dis = v;
    chk("R4 lock_dis write", lock_dis, v);
  endtask

  task automatic pulse_abort(int w);
    case (w)
      0: seq_err = 1'b1;
      1: cpu_off = 1'b1;
      2: flash_stop = 1'b1;
      default: cmd_rst = 1'b1;
    endcase
    @(negedge clk);
    seq_err = 1'b0; cpu_off = 1'b0; flash_stop = 1'b0; cmd_rst = 1'b0;
    exp_dis = 1'b0;
    chk("R7 abort clears lock_dis", lock_dis, 0);
  endtask

  task automatic read_blk(int b, string req);
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_blk = BW'(b);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({req, " rd_valid"}, rd_valid, 1);
    chk({req, " rd_lock"}, rd_lock, exp_lock[b]);
  endtask

  task automatic run_cmd(int op, int b);
    bit acc;
    int n;
    acc = accepts(op, b);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_blk = BW'(b);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!acc) begin
      exp_err = 1'b1;
      chk("R3 reject keeps ready", ready, 1);
      chk("R3 reject sets err", err, 1);
    end else begin
      n = 0;
      while (!ready && n < 100) begin
        n++;
        @(negedge clk);
      end
      chk("R8 busy length", n, len_of(op));
      exp_dis = 1'b0;
      if (op == 1) exp_lock[b] = 1'b1;
      if (op == 2) exp_lock[b] = 1'b0;
      chk("R6 done clears lock_dis", lock_dis, 0);
      chk("R3 err sticky", err, exp_err);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_ni = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_blk = '0;
    dis_wr = 1'b0; dis_val = 1'b0; seq_err = 1'b0; cpu_off = 1'b0;
    flash_stop = 1'b0; cmd_rst = 1'b0;
    exp_dis = 1'b0; exp_err = 1'b0;
    for (int i = 0; i < NB; i++) exp_lock[i] = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", ready, 1);
    chk("R1 lock_dis", lock_dis, 0);
    chk("R1 err", err, 0);
    chk("R1 rd_valid", rd_valid, 0);
    for (int i = 0; i < NB; i++) read_blk(i, "R1 reset lock");

    // R2 lock program, R3 rejection
    run_cmd(2, 2);
    read_blk(2, "R2 locked");
    run_cmd(0, 2);
    run_cmd(1, 2);
    chk("R10 read no busy", ready, 1);

    // R4 override, bits untouched
    write_dis(1'b1);
    read_blk(2, "R4 stored bit kept");
    chk("R4 read keeps lock_dis", lock_dis, 1);
    run_cmd(0, 2);
    read_blk(2, "R5 program keeps lock");
    write_dis(1'b1);
    run_cmd(1, 2);
    read_blk(2, "R5 erase unlocks");

    // R8 commands while busy are ignored
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_blk = 3'd0;
    @(negedge clk);
    cmd_op = 2'd2;
    @(negedge clk);
    cmd_op = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 no read while busy", rd_valid, 0);
    while (!ready) @(negedge clk);
    exp_dis = 1'b0;
    read_blk(0, "R8 ignored lock program");

    // R9 command reset mid-erase, same-cycle command ignored
    run_cmd(2, 3);
    write_dis(1'b1);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_blk = 3'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 busy before abort", ready, 0);
    cmd_rst = 1'b1; cmd_valid = 1'b1; cmd_op = 2'd2; cmd_blk = 3'd4;
    @(negedge clk);
    cmd_rst = 1'b0; cmd_valid = 1'b0;
    exp_dis = 1'b0;
    chk("R9 ready after abort", ready, 1);
    chk("R9 lock_dis cleared", lock_dis, 0);
    read_blk(3, "R9 lock kept");
    read_blk(4, "R9 same-cycle cmd ignored");

    // R7 each abort source, and abort against a same-cycle write
    for (int w = 0; w < 4; w++) begin
      write_dis(1'b1);
      pulse_abort(w);
    end
    dis_wr = 1'b1; dis_val = 1'b1; seq_err = 1'b1;
    @(negedge clk);
    dis_wr = 1'b0; seq_err = 1'b0;
    chk("R7 abort beats write", lock_dis, 0);

    // R6 write landing on the completion edge
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_blk = 3'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (PC - 1) @(negedge clk);
    chk("R6 still busy", ready, 0);
    dis_wr = 1'b1; dis_val = 1'b1;
    @(negedge clk);
    dis_wr = 1'b0;
    chk("R6 ready on completion", ready, 1);
    chk("R6 clear beats write", lock_dis, 0);
    exp_dis = 1'b0;

    // random mix
    for (int it = 0; it < 300; it++) begin
      int r, op, b;
      r  = $urandom_range(0, 9);
      op = $urandom_range(0, 3);
      b  = $urandom_range(0, NB - 1);
      if (r < 3) write_dis(1'b1);
      else if (r == 3) begin
        write_dis(1'b1);
        pulse_abort($urandom_range(0, 2));
      end
      if (op == 3) read_blk(b, "R10 random read");
      else run_cmd(op, b);
    end
    for (int i = 0; i < NB; i++) read_blk(i, "R10 final read");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule